// File: doc/BRIEF.md
# Logic Analyzer Trigger Combiner

This block decides when a logic analyzer starts capturing. A set of probe buses is sampled every cycle of the user clock. Each probe has its own comparator, which a host programs with an operation and an argument. The operations are edge-style tests against the previous sample and magnitude tests against the argument. The per-probe results feed one wide gate, which can be set at run time to require every enabled probe (AND) or any enabled probe (OR). The gate output is registered and becomes the trigger for the capture state machine, which lies outside this block along with the sample memory.

The host writes the configuration through a simple write port clocked by the bus clock. That bank of registers sits in its own module. Its contents are quasi-static, so they cross into the user domain through a plain two-stage synchronizer. When the `EXT_TRIG` parameter is set, none of this logic is built and an externally supplied trigger is passed straight to the output.

Top module: `trg_combiner`

## Requirements
- R1: Once either reset is released, every probe operation reads as disabled, the gate is in AND mode and `trig_out` is 0.
- R2: Operation codes 4, 5, 6 and 7 fire when the probe is equal to, not equal to, unsigned greater than, or unsigned less than its argument.
- R3: Operation codes 1, 2 and 3 compare the sample with the probe value registered on the previous user clock edge. They fire when the sample is unsigned greater than the previous value (rise), unsigned less than it (fall), or different from it (change).
- R4: In AND mode (mode bit 0), the trigger fires when every enabled probe fires.
- R5: In OR mode (mode bit 1), the trigger fires when at least one enabled probe fires.
- R6: A probe with operation code 0 acts as a neutral input: 1 in AND mode and 0 in OR mode. When every probe has code 0, the trigger never fires in either mode.
- R7: `trig_out` is registered. It changes on the first user clock edge that samples a qualifying probe value and stays unchanged before that edge.
- R8: The write map works as follows. Address 0 bit 0 sets the mode. Address 2i+1 bits [2:0] set the operation of probe i. Address 2i+2 bits [PW-1:0] set the argument of probe i. Writes to any other address change nothing.
- R9: A bus write takes effect for samples taken three user clock cycles after the bus edge that captured it.
- R10: With `EXT_TRIG`=1, `trig_out` equals `ext_trig` in the same cycle and ignores the probes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Configuration bus clock |
| bus_rst_n | input | 1 | Active-low asynchronous reset, bus domain |
| bus_wr_en | input | 1 | Write strobe |
| bus_addr | input | AW | Register address, AW = clog2(2*NPROBE+1) |
| bus_wdata | input | DW | Write data |
| usr_clk | input | 1 | User (sampling) clock |
| usr_rst_n | input | 1 | Active-low asynchronous reset, user domain |
| probes | input | NPROBE*PW | Probe buses, probe i at bits [i*PW +: PW] |
| ext_trig | input | 1 | External trigger, used only when EXT_TRIG=1 |
| trig_out | output | 1 | Trigger to the capture state machine |

## Verification
A probe value that qualifies is due on `trig_out` one user cycle later, so the bench drives probes on a falling edge and reads the trigger on the next falling edge. Every value it reads is therefore the result of exactly one rising edge. The latency check also reads the output before that edge, to confirm that nothing has changed yet. Configuration writes are followed by a wait longer than the three-cycle synchronizer latency, and one test waits exactly that budget. The external-trigger variant is combinational and is read 1 ns after `ext_trig` is driven.

// File: rtl/trg_pkg.sv
package trg_pkg;
  localparam int OP_W = 3;
  typedef enum logic [OP_W-1:0] {
    OP_OFF    = 3'd0,
    OP_RISE   = 3'd1,
    OP_FALL   = 3'd2,
    OP_CHANGE = 3'd3,
    OP_EQ     = 3'd4,
    OP_NE     = 3'd5,
    OP_GT     = 3'd6,
    OP_LT     = 3'd7
  } trg_op_e;
endpackage

// File: rtl/trg_cfg_bank.sv
module trg_cfg_bank #(
  parameter int NPROBE = 4,
  parameter int PW     = 8,
  parameter int DW     = 16,
  parameter int AW     = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  wr_en,
  input  logic [AW-1:0]                         addr,
  input  logic [DW-1:0]                         wdata,
  output logic                                  mode_or,
  output logic [NPROBE-1:0][trg_pkg::OP_W-1:0]  ops,
  output logic [NPROBE-1:0][PW-1:0]             args
);
  // whole word is referenced so unused upper bits raise no warning
  logic unused_wdata;
  assign unused_wdata = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_or <= 1'b0;
      ops     <= '0;
      args    <= '0;
    end else if (wr_en) begin
      if (addr == '0) mode_or <= wdata[0];
      for (int i = 0; i < NPROBE; i++) begin
        if (addr == AW'(2*i + 1)) ops[i]  <= wdata[trg_pkg::OP_W-1:0];
        if (addr == AW'(2*i + 2)) args[i] <= wdata[PW-1:0];
      end
    end
  end
endmodule

// File: rtl/trg_cfg_sync.sv
module trg_cfg_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe[0] <= '0;
    else        pipe[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[s] <= '0;
      else        pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/trg_probe_unit.sv
module trg_probe_unit #(
  parameter int PW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PW-1:0]     sample,
  input  trg_pkg::trg_op_e  op,
  input  logic [PW-1:0]     arg,
  output logic              hit
);
  import trg_pkg::*;

  logic [PW-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sample;
  end

  always_comb begin
    unique case (op)
      OP_RISE:   hit = sample >  prev_q;
      OP_FALL:   hit = sample <  prev_q;
      OP_CHANGE: hit = sample != prev_q;
      OP_EQ:     hit = sample == arg;
      OP_NE:     hit = sample != arg;
      OP_GT:     hit = sample >  arg;
      OP_LT:     hit = sample <  arg;
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/trg_combiner.sv
module trg_combiner #(
  parameter int NPROBE   = 4,
  parameter int PW       = 8,
  parameter int DW       = 16,
  parameter bit EXT_TRIG = 1'b0,
  localparam int AW      = $clog2(2*NPROBE + 1)
) (
  input  logic                 bus_clk,
  input  logic                 bus_rst_n,
  input  logic                 bus_wr_en,
  input  logic [AW-1:0]        bus_addr,
  input  logic [DW-1:0]        bus_wdata,
  input  logic                 usr_clk,
  input  logic                 usr_rst_n,
  input  logic [NPROBE*PW-1:0] probes,
  input  logic                 ext_trig,
  output logic                 trig_out
);
  import trg_pkg::*;

  localparam int CFG_W = 1 + NPROBE*OP_W + NPROBE*PW;

  // user-domain view of the configuration and per-probe results
  logic                         mode_or_u;
  logic [NPROBE-1:0][OP_W-1:0]  op_u;
  logic [NPROBE-1:0][PW-1:0]    arg_u;
  logic [NPROBE-1:0]            en_u;
  logic [NPROBE-1:0]            hit_vec;

  if (EXT_TRIG) begin : g_ext
    logic unused_pins;
    assign unused_pins = ^{bus_clk, bus_rst_n, bus_wr_en, bus_addr, bus_wdata,
                           usr_clk, usr_rst_n, probes};
    assign mode_or_u = 1'b0;
    assign op_u      = '0;
    assign arg_u     = '0;
    assign en_u      = '0;
    assign hit_vec   = '0;
    assign trig_out  = ext_trig;
  end else begin : g_int
    logic                         mode_or_b;
    logic [NPROBE-1:0][OP_W-1:0]  op_b;
    logic [NPROBE-1:0][PW-1:0]    arg_b;
    logic [CFG_W-1:0]             cfg_b, cfg_u;
    logic [NPROBE-1:0]            term;
    logic                         trig_q;
    logic                         unused_ext;

    assign unused_ext = ext_trig;

    trg_cfg_bank #(.NPROBE(NPROBE), .PW(PW), .DW(DW), .AW(AW)) u_bank (
      .clk(bus_clk), .rst_n(bus_rst_n), .wr_en(bus_wr_en), .addr(bus_addr),
      .wdata(bus_wdata), .mode_or(mode_or_b), .ops(op_b), .args(arg_b)
    );

    assign cfg_b = {arg_b, op_b, mode_or_b};

    trg_cfg_sync #(.W(CFG_W), .STAGES(2)) u_sync (
      .clk(usr_clk), .rst_n(usr_rst_n), .d(cfg_b), .q(cfg_u)
    );

    assign {arg_u, op_u, mode_or_u} = cfg_u;

    for (genvar i = 0; i < NPROBE; i++) begin : g_probe
      assign en_u[i] = (op_u[i] != OP_OFF);

      trg_probe_unit #(.PW(PW)) u_unit (
        .clk(usr_clk), .rst_n(usr_rst_n),
        .sample(probes[i*PW +: PW]),
        .op(trg_op_e'(op_u[i])),
        .arg(arg_u[i]),
        .hit(hit_vec[i])
      );

      // disabled probes present the identity element of the selected gate
      assign term[i] = en_u[i] ? hit_vec[i] : ~mode_or_u;
    end

    always_ff @(posedge usr_clk or negedge usr_rst_n) begin
      if (!usr_rst_n) trig_q <= 1'b0;
      else            trig_q <= (|en_u) & (mode_or_u ? (|term) : (&term));
    end

    assign trig_out = trig_q;
  end
endmodule

// File: rtl/trg_combiner_chk.sv
module trg_combiner_chk #(
  parameter int NPROBE   = 4,
  parameter bit EXT_TRIG = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_or,
  input logic [NPROBE-1:0] en,
  input logic [NPROBE-1:0] hit,
  input logic              ext_trig,
  input logic              trig
);
  if (EXT_TRIG) begin : g_ext
    logic unused_int;
    assign unused_int = ^{mode_or, en, hit};

    p_ext_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      trig == ext_trig);
  end else begin : g_int
    logic unused_ext;
    assign unused_ext = ext_trig;

    p_reset_low_r1: assert property (@(posedge clk)
      $rose(rst_n) |-> !trig);

    p_hit_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (hit & ~en) == '0);

    p_all_off_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (en == '0) |=> !trig);

    p_and_fire_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_or && en != '0 && (hit | ~en) == '1) |=> trig);

    p_and_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_or && (hit | ~en) != '1) |=> !trig);

    p_or_fire_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_or && (hit & en) != '0) |=> trig);

    p_or_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_or && (hit & en) == '0) |=> !trig);
  end
endmodule

bind trg_combiner trg_combiner_chk #(.NPROBE(NPROBE), .EXT_TRIG(EXT_TRIG)) u_chk (
  .clk(usr_clk), .rst_n(usr_rst_n), .mode_or(mode_or_u), .en(en_u),
  .hit(hit_vec), .ext_trig(ext_trig), .trig(trig_out)
);

// File: tb/trg_combiner_bench.sv
`timescale 1ns/1ps
module trg_combiner_bench;
  localparam int NPROBE = 4;
  localparam int PW     = 8;
  localparam int DW     = 16;
  localparam int AW     = $clog2(2*NPROBE + 1);

  logic                 bus_clk = 1'b0, usr_clk = 1'b0;
  logic                 bus_rst_n = 1'b0, usr_rst_n = 1'b0;
  logic                 bus_wr_en = 1'b0;
  logic [AW-1:0]        bus_addr = '0;
  logic [DW-1:0]        bus_wdata = '0;
  logic [NPROBE*PW-1:0] probes = '0;
  logic                 ext_trig = 1'b0;
  logic                 trig_out, trig_ext;

  int n_checks = 0;
  int n_errors = 0;

  always #2 usr_clk = ~usr_clk;
  always #3 bus_clk = ~bus_clk;

  trg_combiner #(.NPROBE(NPROBE), .PW(PW), .DW(DW)) u_trg_combiner (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .bus_wr_en(bus_wr_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .usr_clk(usr_clk),
    .usr_rst_n(usr_rst_n), .probes(probes), .ext_trig(ext_trig),
    .trig_out(trig_out)
  );

  trg_combiner #(.NPROBE(NPROBE), .PW(PW), .DW(DW), .EXT_TRIG(1'b1)) u_ext (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .bus_wr_en(bus_wr_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .usr_clk(usr_clk),
    .usr_rst_n(usr_rst_n), .probes(probes), .ext_trig(ext_trig),
    .trig_out(trig_ext)
  );

  task automatic check(input string req, input string what,
                       input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic bus_wr(input int a, input int d);
    @(negedge bus_clk);
    bus_wr_en = 1'b1;
    bus_addr  = AW'(a);
    bus_wdata = DW'(d);
    @(negedge bus_clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic settle();
    repeat (8) @(negedge usr_clk);
  endtask

  // drive one pattern; the trigger for it is due after the next rising edge
  task automatic drive(input logic [31:0] pv, input logic exp,
                       input string req, input string what);
    @(negedge usr_clk);
    probes = pv;
    @(negedge usr_clk);
    check(req, what, trig_out, exp);
  endtask

  task automatic t_reset();
    check("R1", "trig after reset", trig_out, 1'b0);
    drive(32'h0000_0000, 1'b0, "R6", "all off AND zeros");
    drive(32'hFFFF_FFFF, 1'b0, "R6", "all off AND ones");
    drive(32'h5A5A_5A5A, 1'b0, "R1", "default config quiet");
  endtask

  task automatic t_compare();
    bus_wr(2, 32'h5A);
    bus_wr(1, 4); settle();
    drive(32'h0000_005A, 1'b1, "R2", "eq match");
    drive(32'h0000_005B, 1'b0, "R2", "eq miss");
    drive(32'hA1B2_C35A, 1'b1, "R6", "eq match others disabled");
    bus_wr(1, 5); settle();
    drive(32'h0000_005A, 1'b0, "R2", "ne equal");
    drive(32'h0000_0011, 1'b1, "R2", "ne differ");
    bus_wr(1, 6); settle();
    drive(32'h0000_005B, 1'b1, "R2", "gt above");
    drive(32'h0000_005A, 1'b0, "R2", "gt equal");
    bus_wr(1, 7); settle();
    drive(32'h0000_0059, 1'b1, "R2", "lt below");
    drive(32'h0000_005A, 1'b0, "R2", "lt equal");
    bus_wr(1, 0);
  endtask

  task automatic t_edges();
    drive(32'h0000_0000, 1'b0, "R6", "idle before edge test");
    bus_wr(5, 1); settle();
    drive(32'h0003_0000, 1'b1, "R3", "rise 0->3");
    drive(32'h0003_0000, 1'b0, "R3", "rise hold 3");
    drive(32'h0007_0000, 1'b1, "R3", "rise 3->7");
    drive(32'h0002_0000, 1'b0, "R3", "rise on drop");
    bus_wr(5, 2); settle();
    drive(32'h0001_0000, 1'b1, "R3", "fall 2->1");
    drive(32'h0001_0000, 1'b0, "R3", "fall hold");
    drive(32'h0009_0000, 1'b0, "R3", "fall on rise");
    bus_wr(5, 3); settle();
    drive(32'h0009_0000, 1'b0, "R3", "change hold");
    drive(32'h0008_0000, 1'b1, "R3", "change 9->8");
    bus_wr(5, 0);
  endtask

  task automatic t_and_or();
    bus_wr(2, 32'h10); bus_wr(1, 4);
    bus_wr(4, 32'h20); bus_wr(3, 6); settle();
    drive(32'h0000_3010, 1'b1, "R4", "and both hit");
    drive(32'h0000_0510, 1'b0, "R4", "and one miss");
    drive(32'h0000_3011, 1'b0, "R4", "and other miss");
    bus_wr(0, 1);
    repeat (3) @(negedge usr_clk);
    drive(32'h0000_3011, 1'b1, "R9", "or active after 3 cycles");
    drive(32'h0000_0511, 1'b0, "R5", "or none hit");
    drive(32'h0000_0510, 1'b1, "R5", "or first hit");
  endtask

  task automatic t_all_off();
    bus_wr(1, 0); bus_wr(3, 0); settle();
    drive(32'h0000_3010, 1'b0, "R6", "or all off");
    drive(32'hFFFF_FFFF, 1'b0, "R6", "or all off ones");
    bus_wr(0, 0); settle();
    drive(32'h1234_5678, 1'b0, "R6", "and all off");
  endtask

  task automatic t_map_and_latency();
    bus_wr(8, 32'h77); bus_wr(7, 4); settle();
    bus_wr(9, 32'hFFFF); bus_wr(15, 32'hFFFF); settle();
    drive(32'h7700_0000, 1'b1, "R8", "p3 eq kept after stray writes");
    drive(32'h7600_0000, 1'b0, "R8", "p3 miss after stray writes");
    @(negedge usr_clk);
    probes = 32'h7700_0000;
    #1 check("R7", "no change before edge", trig_out, 1'b0);
    @(negedge usr_clk);
    check("R7", "asserted one edge later", trig_out, 1'b1);
    probes = 32'h7600_0000;
    #1 check("R7", "held until next edge", trig_out, 1'b1);
    @(negedge usr_clk);
    check("R7", "released after edge", trig_out, 1'b0);
  endtask

  task automatic t_ext();
    @(negedge usr_clk);
    ext_trig = 1'b1; probes = 32'h0;
    #1 check("R10", "ext high passes", trig_ext, 1'b1);
    ext_trig = 1'b0;
    #1 check("R10", "ext low passes", trig_ext, 1'b0);
    probes = 32'h7700_0000;
    @(negedge usr_clk);
    check("R10", "probes ignored", trig_ext, 1'b0);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge usr_clk);
    bus_rst_n = 1'b1;
    usr_rst_n = 1'b1;
    @(negedge usr_clk);
    t_reset();
    t_compare();
    t_edges();
    t_and_or();
    t_all_off();
    t_map_and_latency();
    t_ext();
    finish_run();
  end

  initial begin
    #(200000 * 4);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end
endmodule